// File: doc/BRIEF.md
# Lockable Security State Controller

This block holds the security posture of a chip as one of four one-hot states: inspect, secure, non-secure and fail. Software reads and writes five 32-bit registers through a plain single-cycle port. It requests state changes by writing the target state. Two health inputs decide whether the secure and non-secure states may be entered. A request that the health inputs do not permit sends the block to fail. The block can leave fail only when a restart permission has been granted, and then only to inspect.

Up to fifteen event inputs are compared against per-state masks. A violation mask for the current state turns a matching event into an immediate move to fail. A separate escalation mask drives two escalation outputs. Every configuration field has a lock bit of its own. Once a lock bit is written to 1, it and the field it guards ignore writes until the next reset.

Top module: `secstate_ctrl`

## Requirements
- R1: After reset the state reads 0x1 (inspect), the words at offsets 0x4, 0x8 and 0xC read 0, and both escalation outputs are low.
- R2: A write to offset 0x0 whose low nibble has exactly one bit set (bit 0 inspect, bit 1 secure, bit 2 non-secure, bit 3 fail) moves a non-fail state to that target at the next clock edge. A write whose low nibble is zero or has several bits set leaves the state unchanged.
- R3: A one-hot request for secure while `sec_ok` is 0, or for non-secure while `nsec_ok` is 0, moves the state to fail. Offset 0x0 reads `sec_ok` in bit 16 and `nsec_ok` in bit 17.
- R4: In fail, a request for inspect succeeds only while the restart bit (bit 0 of offset 0x4) is 1. Every other request made in fail is ignored.
- R5: Bit 3 of offset 0x4 is a lock bit. Once it reads 1, writes to offset 0x4 change neither it nor the restart bit until reset.
- R6: Offset 0x8 holds the secure violation mask in bits 14:0 with its lock in bit 15, and the non-secure violation mask in bits 30:16 with its lock in bit 31. Each lock freezes only its own half.
- R7: Offset 0xC holds the secure and non-secure escalation masks in the same layout as offset 0x8, each half with its own lock.
- R8: In secure, an event enabled in the secure violation mask moves the state to fail at the next edge. In non-secure, the non-secure violation mask is used in the same way. An event enabled only in the other state's mask has no effect.
- R9: When a violation and a state write occur in the same cycle, the state goes to fail.
- R10: `esc_sec` is high in the same cycle that the state is secure and some event enabled in the secure escalation mask is high. `esc_nsec` works the same way for non-secure. Offset 0x10 reads the events in bits 30:16, `esc_sec` in bit 0 and `esc_nsec` in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sec_ok | input | 1 | Health permits entry to secure |
| nsec_ok | input | 1 | Health permits entry to non-secure |
| evt_in | input | EVT_W | Security event levels |
| sec_state | output | 4 | One-hot state: inspect, secure, non-secure, fail |
| esc_sec | output | 1 | Secure escalation active |
| esc_nsec | output | 1 | Non-secure escalation active |

## Verification
The assertions assume that `evt_in`, `sec_ok` and `nsec_ok` are level signals that are stable around the clock edge, and that a write strobe lasts exactly one cycle with its address and data held alongside it. The bench changes every input at the falling edge and raises `reg_wr` for one cycle per access, so each rising edge sees settled values. The bench samples results only at falling edges. Event sweeps drive a single event bit at a time against a single-bit mask, with its complement in the other state's mask, so that each violation or escalation has one cause.

// File: rtl/secstate_ctrl.sv
module secstate_ctrl #(
  parameter int EVT_W  = 15,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sec_ok,
  input  logic              nsec_ok,
  input  logic [EVT_W-1:0]  evt_in,
  output logic [3:0]        sec_state,
  output logic              esc_sec,
  output logic              esc_nsec
);
  localparam logic [3:0] ST_INS = 4'b0001;
  localparam logic [3:0] ST_SEC = 4'b0010;
  localparam logic [3:0] ST_NSC = 4'b0100;
  localparam logic [3:0] ST_FAIL = 4'b1000;
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VIO   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_ESC   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_EVT   = ADDR_W'(16);
  localparam int HI = 16;

  logic [3:0]       st, st_nxt;
  logic             restart, cfg_lock;
  logic [EVT_W-1:0] vm_s, vm_n, em_s, em_n;
  logic             vl_s, vl_n, el_s, el_n;

  wire wr_st  = reg_wr && reg_addr == A_STATE;
  wire wr_cfg = reg_wr && reg_addr == A_CFG;
  wire wr_vio = reg_wr && reg_addr == A_VIO;
  wire wr_esc = reg_wr && reg_addr == A_ESC;

  wire [3:0] tgt    = reg_wdata[3:0];
  wire       tgt_oh = (tgt != 4'b0) && ((tgt & (tgt - 4'd1)) == 4'b0);

  wire vio = (st == ST_SEC && |(evt_in & vm_s)) ||
             (st == ST_NSC && |(evt_in & vm_n));

  assign esc_sec   = st == ST_SEC && |(evt_in & em_s);
  assign esc_nsec  = st == ST_NSC && |(evt_in & em_n);
  assign sec_state = st;

  always_comb begin
    st_nxt = st;
    if (vio)
      st_nxt = ST_FAIL;
    else if (wr_st && tgt_oh) begin
      if (st == ST_FAIL) begin
        if (tgt == ST_INS && restart) st_nxt = ST_INS;
      end else begin
        case (tgt)
          ST_SEC:  st_nxt = sec_ok  ? ST_SEC : ST_FAIL;
          ST_NSC:  st_nxt = nsec_ok ? ST_NSC : ST_FAIL;
          default: st_nxt = tgt;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_INS;
    else        st <= st_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      restart  <= 1'b0;
      cfg_lock <= 1'b0;
    end else if (wr_cfg && !cfg_lock) begin
      restart  <= reg_wdata[0];
      cfg_lock <= reg_wdata[3];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vm_s <= '0; vl_s <= 1'b0; vm_n <= '0; vl_n <= 1'b0;
    end else if (wr_vio) begin
      if (!vl_s) begin
        vm_s <= reg_wdata[EVT_W-1:0];
        vl_s <= reg_wdata[HI-1];
      end
      if (!vl_n) begin
        vm_n <= reg_wdata[HI +: EVT_W];
        vl_n <= reg_wdata[31];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      em_s <= '0; el_s <= 1'b0; em_n <= '0; el_n <= 1'b0;
    end else if (wr_esc) begin
      if (!el_s) begin
        em_s <= reg_wdata[EVT_W-1:0];
        el_s <= reg_wdata[HI-1];
      end
      if (!el_n) begin
        em_n <= reg_wdata[HI +: EVT_W];
        el_n <= reg_wdata[31];
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATE: begin
        reg_rdata[3:0] = st;
        reg_rdata[16]  = sec_ok;
        reg_rdata[17]  = nsec_ok;
      end
      A_CFG: begin
        reg_rdata[0] = restart;
        reg_rdata[3] = cfg_lock;
      end
      A_VIO: begin
        reg_rdata[EVT_W-1:0]   = vm_s;
        reg_rdata[HI-1]        = vl_s;
        reg_rdata[HI +: EVT_W] = vm_n;
        reg_rdata[31]          = vl_n;
      end
      A_ESC: begin
        reg_rdata[EVT_W-1:0]   = em_s;
        reg_rdata[HI-1]        = el_s;
        reg_rdata[HI +: EVT_W] = em_n;
        reg_rdata[31]          = el_n;
      end
      A_EVT: begin
        reg_rdata[HI +: EVT_W] = evt_in;
        reg_rdata[0]           = esc_sec;
        reg_rdata[1]           = esc_nsec;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/secstate_ctrl_chk.sv
module secstate_ctrl_chk #(
  parameter int EVT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       st,
  input logic             sec_ok,
  input logic [EVT_W-1:0] evt_in,
  input logic [EVT_W-1:0] vm_s,
  input logic [EVT_W-1:0] vm_n,
  input logic             restart,
  input logic             cfg_lock,
  input logic             vl_s,
  input logic             el_n,
  input logic [EVT_W-1:0] em_n,
  input logic             esc_sec,
  input logic             esc_nsec
);
  // R2
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1);
  // R3
  sec_entry_health_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b0010 && $past(st) != 4'b0010) |-> $past(sec_ok));
  // R4
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b1000 && !restart) |=> st == 4'b1000);
  // R5
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> (cfg_lock && $stable(restart)));
  // R6
  vio_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_s |=> (vl_s && $stable(vm_s)));
  // R7
  esc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    el_n |=> (el_n && $stable(em_n)));
  // R8
  sec_vio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b0010 && |(evt_in & vm_s)) |=> st == 4'b1000);
  // R8
  nsec_vio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'b0100 && |(evt_in & vm_n)) |=> st == 4'b1000);
  // R10
  esc_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(esc_sec && esc_nsec) && (!esc_sec || st == 4'b0010) && (!esc_nsec || st == 4'b0100));
endmodule

bind secstate_ctrl secstate_ctrl_chk #(.EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .sec_ok(sec_ok), .evt_in(evt_in),
  .vm_s(vm_s), .vm_n(vm_n), .restart(restart), .cfg_lock(cfg_lock),
  .vl_s(vl_s), .el_n(el_n), .em_n(em_n), .esc_sec(esc_sec), .esc_nsec(esc_nsec)
);

// File: tb/secstate_ctrl_bench.sv
module secstate_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int EW = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sec_ok = 1'b0, nsec_ok = 1'b0;
  logic [EW-1:0] evt_in = '0;
  logic [3:0]  sec_state;
  logic        esc_sec, esc_nsec;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  secstate_ctrl u_secstate_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_ok(sec_ok),
    .nsec_ok(nsec_ok), .evt_in(evt_in), .sec_state(sec_state),
    .esc_sec(esc_sec), .esc_nsec(esc_nsec));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [3:0] exp_move(input logic [3:0] t, input logic so, input logic no);
    if (t == 4'b0001) return 4'b0001;
    if (t == 4'b0010) return so ? 4'b0010 : 4'b1000;
    if (t == 4'b0100) return no ? 4'b0100 : 4'b1000;
    if (t == 4'b1000) return 4'b1000;
    return 4'b0001;
  endfunction

  task automatic reset_checks();
    logic [31:0] d;
    chk("R1 state", {28'b0, sec_state}, 32'h1);
    rd(5'd0, d);  chk("R1 rd 0x0", d, 32'h1);
    rd(5'd4, d);  chk("R1 rd 0x4", d, 32'h0);
    rd(5'd8, d);  chk("R1 rd 0x8", d, 32'h0);
    rd(5'd12, d); chk("R1 rd 0xC", d, 32'h0);
    chk("R1 esc", {30'b0, esc_nsec, esc_sec}, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_checks();

    // R2 / R3 sweep over all nibbles and health combinations
    wr(5'd4, 32'h1);
    for (int t = 0; t < 16; t++)
      for (int h = 0; h < 4; h++) begin
        sec_ok = h[0]; nsec_ok = h[1];
        wr(5'd0, 32'h1);
        wr(5'd0, 32'(t));
        chk((t == 2 || t == 4) ? "R3 gated entry" : "R2 move", {28'b0, sec_state},
            {28'b0, exp_move(4'(t), h[0], h[1])});
      end

    // R3 health flags readback
    sec_ok = 1'b1; nsec_ok = 1'b0;
    wr(5'd0, 32'h1);
    rd(5'd0, d); chk("R3 flags sec", d, 32'h0001_0001);
    sec_ok = 1'b0; nsec_ok = 1'b1;
    rd(5'd0, d); chk("R3 flags nsec", d, 32'h0002_0001);

    // R4 restart gating
    sec_ok = 1'b1; nsec_ok = 1'b1;
    wr(5'd4, 32'h0);
    wr(5'd0, 32'h8);
    wr(5'd0, 32'h1); chk("R4 no restart", {28'b0, sec_state}, 32'h8);
    wr(5'd0, 32'h2); chk("R4 fail ignores secure", {28'b0, sec_state}, 32'h8);
    wr(5'd4, 32'h1);
    wr(5'd0, 32'h4); chk("R4 fail ignores nsec", {28'b0, sec_state}, 32'h8);
    wr(5'd0, 32'h1); chk("R4 restart ok", {28'b0, sec_state}, 32'h1);

    // R8 violation sweep, secure state
    for (int i = 0; i < EW; i++) begin
      logic [EW-1:0] b;
      b = EW'(1) << i;
      wr(5'd8, {1'b0, ~b, 1'b0, b});
      wr(5'd0, 32'h2);
      @(negedge clk); evt_in = ~b;
      @(negedge clk); chk("R8 other mask ignored", {28'b0, sec_state}, 32'h2);
      evt_in = b;
      @(negedge clk); chk("R8 secure violation", {28'b0, sec_state}, 32'h8);
      evt_in = '0;
      wr(5'd0, 32'h1);
    end
    // R8 non-secure
    for (int i = 0; i < EW; i++) begin
      logic [EW-1:0] b;
      b = EW'(1) << i;
      wr(5'd8, {1'b0, b, 1'b0, ~b});
      wr(5'd0, 32'h4);
      @(negedge clk); evt_in = ~b;
      @(negedge clk); chk("R8 other mask ignored nsec", {28'b0, sec_state}, 32'h4);
      evt_in = b;
      @(negedge clk); chk("R8 nsec violation", {28'b0, sec_state}, 32'h8);
      evt_in = '0;
      wr(5'd0, 32'h1);
    end

    // R9 violation beats write
    wr(5'd8, 32'h0000_0001);
    wr(5'd0, 32'h2);
    @(negedge clk);
    evt_in = 'h1; reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    chk("R9 priority", {28'b0, sec_state}, 32'h8);
    wr(5'd0, 32'h1);

    // R10 escalation
    wr(5'd8, 32'h0);
    wr(5'd12, 32'h0100_0005);
    evt_in = 'h1; #1;
    chk("R10 inspect no esc", {30'b0, esc_nsec, esc_sec}, 32'h0);
    wr(5'd0, 32'h2);
    evt_in = 'h4;
    rd(5'd16, d); chk("R10 esc_sec", d, 32'h0004_0001);
    evt_in = 'h2;
    rd(5'd16, d); chk("R10 unmasked event", d, 32'h0002_0000);
    evt_in = 'h100;
    rd(5'd16, d); chk("R10 nsec mask in secure", d, 32'h0100_0000);
    evt_in = '0;
    wr(5'd0, 32'h1);
    wr(5'd0, 32'h4);
    evt_in = 'h100;
    rd(5'd16, d); chk("R10 esc_nsec", d, 32'h0100_0002);
    chk("R10 esc pins", {30'b0, esc_nsec, esc_sec}, 32'h2);
    evt_in = '0;
    wr(5'd0, 32'h1);

    // R5 config lock
    wr(5'd4, 32'h9);
    rd(5'd4, d); chk("R5 lock set", d, 32'h9);
    wr(5'd4, 32'h0);
    rd(5'd4, d); chk("R5 write ignored", d, 32'h9);

    // R6 violation locks
    wr(5'd8, 32'h0000_8003);
    wr(5'd8, 32'h7FFF_7FFF);
    rd(5'd8, d); chk("R6 secure half locked", d, 32'h7FFF_8003);
    wr(5'd8, 32'h8000_0001);
    wr(5'd8, 32'hFFFF_FFFF);
    rd(5'd8, d); chk("R6 both halves locked", d, 32'h8000_8003);

    // R7 escalation locks
    wr(5'd12, 32'h0001_8000);
    wr(5'd12, 32'hFFFF_7FFF);
    rd(5'd12, d); chk("R7 secure half locked", d, 32'hFFFF_8000);
    wr(5'd12, 32'h0);
    rd(5'd12, d); chk("R7 both halves locked", d, 32'hFFFF_8000);

    // R1 reset clears locks
    sec_ok = 1'b0; nsec_ok = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reset_checks();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule